// File: doc/BRIEF.md
# Input capture channel with capture FIFO

This block is one timestamp channel. It watches an external pin, passes the pin through a synchronizer and finds its edges. When the programmed edge condition is met, it records the value of one of two free-running 16-bit time-base buses. A host can then measure periods or pulse widths by taking the difference between successive stamps.

Stamps go into a four-word FIFO. The host reads this FIFO through one data port and a read strobe. After a programmable number of stored captures, the channel pulses an interrupt. A further mode stores nothing. In that mode every pin edge only pulses the interrupt and a wake flag, so the pin can act as a plain external event source.

Top module: `ic_channel`

## Requirements
- R1: `tsel_i` picks the timer bus that is stamped. 0 selects `tmr_a_i` and 1 selects `tmr_b_i`. The stored value is the selected bus as it stands on the clock edge that writes the entry.
- R2: With `mode_i` = 3'b001, every rising edge and every falling edge of the synchronized pin stores one stamp.
- R3: With `mode_i` = 3'b010 only falling edges store a stamp. With 3'b011 only rising edges store a stamp.
- R4: With `mode_i` = 3'b100 every 4th rising edge stores a stamp. With 3'b101 every 16th rising edge stores a stamp. Falling edges are not counted.
- R5: Any change of `mode_i` clears the rising-edge prescale count, so the next count of 4 or 16 starts from zero.
- R6: With `mode_i` = 3'b111, each pin edge of either polarity pulses `wake_o` and `irq_o` for one cycle and stores nothing.
- R7: The FIFO holds 4 entries and gives them out oldest first. `rdata_o` shows the oldest entry. `nempty_o` is high while an entry is held. A cycle with `rd_i` high removes the shown entry. `rd_i` has no effect while the FIFO is empty.
- R8: A capture that arrives while 4 entries are held is dropped and sets `ovf_o`. `ovf_o` stays set until the FIFO becomes empty.
- R9: `irq_o` pulses for one cycle once every `ithr_i`+1 stored captures. 2'b00 pulses on every capture and 2'b11 pulses on every 4th.
- R10: `mode_i` = 3'b000 turns the channel off. This empties the FIFO and clears `ovf_o`, the prescale count and the interrupt capture count.
- R11: After reset, `nempty_o`, `ovf_o`, `irq_o` and `wake_o` are low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| tmr_a_i | input | 16 | First time-base value |
| tmr_b_i | input | 16 | Second time-base value |
| mode_i | input | 3 | Capture mode |
| tsel_i | input | 1 | Time-base select |
| ithr_i | input | 2 | Captures per interrupt, minus one |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| rdata_o | output | 16 | Oldest stored stamp |
| nempty_o | output | 1 | FIFO holds at least one entry |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wake_o | output | 1 | One-cycle wake pulse in wake-only mode |

## Verification
The pin is toggled through slow rise and fall pairs under each edge mode, with a distinct pair of timer values for each edge. A stamp from the wrong polarity, the wrong edge count or the wrong bus shows up in the queue as an extra, missing or mismatched word. Rising trains of 8 and 16 edges show apart the two prescale ratios. A partial count interrupted by mode toggles shows whether the prescale count is restarted. Five captures with no reads, strobes on an empty FIFO and different threshold settings show apart drop-on-full, sticky overflow, pointer underflow and the interrupt cadence.

// File: rtl/ic_channel.sv
module ic_channel #(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic [2:0]    mode_i,
  input  logic          tsel_i,
  input  logic [1:0]    ithr_i,
  input  logic          rd_i,
  output logic [TW-1:0] rdata_o,
  output logic          nempty_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic          wake_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DIV_B);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [2:0]      mode_q;
  logic [PW-1:0]   pre_q;
  logic [TW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic [1:0]      icnt_q;
  logic            cap, push, pop, full, off, mode_chg, pre_mode, pre_hit, anyedge;

  wire lvl  = sync_q[SYNC-1];
  wire rise = lvl & ~prev_q;
  wire fall = ~lvl & prev_q;
  wire [TW-1:0] stamp   = tsel_i ? tmr_b_i : tmr_a_i;
  wire [PW-1:0] pre_lim = (mode_i == 3'b101) ? PW'(DIV_B - 1) : PW'(DIV_A - 1);

  assign anyedge  = rise | fall;
  assign off      = (mode_i == 3'b000);
  assign mode_chg = (mode_i != mode_q);
  assign pre_mode = (mode_i == 3'b100) || (mode_i == 3'b101);
  assign pre_hit  = pre_mode && rise && !mode_chg && (pre_q == pre_lim);
  assign full     = (cnt_q == CW'(DEPTH));
  assign push     = cap && !full;
  assign pop      = rd_i && (cnt_q != '0) && !off;
  assign cnt_nxt  = cnt_q + CW'(push) - CW'(pop);

  always_comb begin
    case (mode_i)
      3'b001:         cap = anyedge;
      3'b010:         cap = fall;
      3'b011:         cap = rise;
      3'b100, 3'b101: cap = pre_hit;
      default:        cap = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mode_q <= 3'b000;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= lvl;
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (off || mode_chg)    pre_q <= '0;
    else if (pre_mode && rise)   pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (off) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem[wp_q] <= stamp;
        wp_q      <= wp_q + 1'b1;
      end
      if (pop) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_o  <= 1'b0;
      icnt_q <= '0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      if (off)                ovf_o <= 1'b0;
      else if (cap && full)   ovf_o <= 1'b1;
      else if (cnt_nxt == '0) ovf_o <= 1'b0;
      if (off)       icnt_q <= '0;
      else if (push) icnt_q <= (icnt_q >= ithr_i) ? 2'd0 : icnt_q + 2'd1;
      irq_o  <= (push && icnt_q >= ithr_i) || (mode_i == 3'b111 && anyedge);
      wake_o <= (mode_i == 3'b111) && anyedge;
    end
  end

  assign rdata_o  = mem[rp_q];
  assign nempty_o = (cnt_q != '0);

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_ovf_from_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(cnt_q) == CW'(DEPTH));
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !nempty_o && !ovf_o);
  assert_wake_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b111) |=> cnt_q <= $past(cnt_q));
  assert_wake_mode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(mode_i) == 3'b111);
endmodule

// File: tb/tb_ic_channel.sv
module tb_ic_channel;
  logic        clk = 1'b0, rst_n = 1'b0, pin_i = 1'b0, tsel_i = 1'b0, rd_i = 1'b0;
  logic [15:0] tmr_a_i = '0, tmr_b_i = '0;
  logic [2:0]  mode_i = 3'b000;
  logic [1:0]  ithr_i = 2'b00;
  logic [15:0] rdata_o;
  logic        nempty_o, ovf_o, irq_o, wake_o;

  ic_channel dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tmr_a_i(tmr_a_i), .tmr_b_i(tmr_b_i),
    .mode_i(mode_i), .tsel_i(tsel_i), .ithr_i(ithr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .nempty_o(nempty_o), .ovf_o(ovf_o), .irq_o(irq_o), .wake_o(wake_o));

  always #2 clk = ~clk;

  logic [15:0] exp_q[$];
  int n_cmp = 0, n_bad = 0, stamp = 0, irq_n = 0, wake_n = 0;
  bit drain_en = 1'b0, poke_rd = 1'b0;
  string tag = "R7";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq_o) irq_n++;
    if (wake_o) wake_n++;
    if (drain_en && nempty_o && !rd_i) begin
      if (exp_q.size() == 0) chk(1'b0, tag, rdata_o, -1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rdata_o == e, tag, rdata_o, e);
      end
      rd_i <= 1'b1;
    end else rd_i <= poke_rd;
  end

  task automatic edge_to(input bit v, input bit expect_cap);
    @(negedge clk);
    stamp++;
    tmr_a_i = 16'h1000 + 16'(stamp * 3);
    tmr_b_i = 16'hA000 ^ 16'(stamp * 7);
    pin_i = v;
    if (expect_cap) exp_q.push_back(tsel_i ? tmr_b_i : tmr_a_i);
    repeat (7) @(negedge clk);
  endtask

  task automatic pulse(input bit cap_rise, input bit cap_fall);
    edge_to(1'b1, cap_rise);
    edge_to(1'b0, cap_fall);
  endtask

  task automatic settle(input string req);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_i = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int i0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!nempty_o && !ovf_o && !irq_o && !wake_o, "R11", {nempty_o, ovf_o, irq_o, wake_o}, 0);
    chk(rdata_o == 16'h0, "R11", rdata_o, 0);

    drain_en = 1'b1;
    tag = "R3"; set_mode(3'b011);
    pulse(1, 0); pulse(1, 0); settle("R3");
    tag = "R1"; tsel_i = 1'b1;
    pulse(1, 0); pulse(1, 0); settle("R1");
    tsel_i = 1'b0;
    tag = "R3"; set_mode(3'b010);
    pulse(0, 1); pulse(0, 1); settle("R3");
    tag = "R2"; set_mode(3'b001);
    pulse(1, 1); pulse(1, 1); settle("R2");

    tag = "R4"; set_mode(3'b100);
    for (int k = 1; k <= 8; k++) pulse(k % 4 == 0, 0);
    settle("R4");
    set_mode(3'b101);
    tsel_i = 1'b1;
    for (int k = 1; k <= 16; k++) pulse(k == 16, 0);
    settle("R4");
    tsel_i = 1'b0;

    tag = "R5"; set_mode(3'b100);
    for (int k = 0; k < 3; k++) pulse(0, 0);
    set_mode(3'b101); set_mode(3'b100);
    for (int k = 1; k <= 4; k++) pulse(k == 4, 0);
    settle("R5");

    tag = "R6"; set_mode(3'b111);
    i0 = irq_n; w0 = wake_n;
    pulse(0, 0);
    chk(wake_n - w0 == 2, "R6", wake_n - w0, 2);
    chk(irq_n - i0 == 2, "R6", irq_n - i0, 2);
    chk(!nempty_o, "R6", nempty_o, 0);

    tag = "R7"; set_mode(3'b011);
    drain_en = 1'b0; poke_rd = 1'b1;
    repeat (4) @(negedge clk);
    poke_rd = 1'b0;
    repeat (2) @(negedge clk);
    pulse(1, 0);
    chk(nempty_o, "R7", nempty_o, 1);
    drain_en = 1'b1; settle("R7");
    chk(!nempty_o, "R7", nempty_o, 0);

    tag = "R8"; drain_en = 1'b0;
    for (int k = 0; k < 5; k++) pulse(k < 4, 0);
    chk(ovf_o, "R8", ovf_o, 1);
    chk(nempty_o, "R8", nempty_o, 1);
    drain_en = 1'b1; settle("R8");
    chk(!ovf_o, "R8", ovf_o, 0);

    tag = "R9"; set_mode(3'b000); ithr_i = 2'd2; set_mode(3'b011);
    i0 = irq_n;
    for (int k = 0; k < 6; k++) pulse(1, 0);
    settle("R9");
    chk(irq_n - i0 == 2, "R9", irq_n - i0, 2);
    set_mode(3'b000); ithr_i = 2'd0; set_mode(3'b011);
    i0 = irq_n;
    for (int k = 0; k < 3; k++) pulse(1, 0);
    settle("R9");
    chk(irq_n - i0 == 3, "R9", irq_n - i0, 3);

    tag = "R10"; drain_en = 1'b0;
    for (int k = 0; k < 5; k++) pulse(0, 0);
    chk(ovf_o && nempty_o, "R10", {ovf_o, nempty_o}, 3);
    set_mode(3'b000);
    chk(!ovf_o && !nempty_o, "R10", {ovf_o, nempty_o}, 0);
    drain_en = 1'b1; set_mode(3'b100);
    for (int k = 1; k <= 4; k++) pulse(k == 4, 0);
    settle("R10");

    summary();
  end
endmodule